// File: doc/BRIEF.md
# Over-Current Pulse-Skip Sequencer

This block handles over-current events for one switching channel, working on the channel's cycles. A one-clock strobe marks the start of each switching cycle, and a separate flag reports that the current limit has been reached. The block samples the flag only on that strobe. When the flag is sampled high while the channel runs normally, the block blocks the high-side drive for that cycle and for the eight cycles after it.

A probation window of eight cycles follows the skip window. During probation the high-side pulses run normally. If the flag is sampled high again at any cycle start inside that window, the block latches off: the drive stays blocked and a power-good-low request is raised. If probation ends without a new event, the block returns to normal and treats the next cycle start as a fresh sample. Only two things release the latch: driving the enable input low, or a reset (a supply cycle).

One 4-bit cycle counter serves both windows. Both window lengths are parameters.

Top module: `ocs_skip_seq`

## Requirements
- R1: While running normally and enabled, if the limit flag is high at a cycle-start strobe, `hs_inhibit` is high from the clock after that strobe. That cycle counts as cycle 0 of the event.
- R2: `hs_inhibit` stays high through cycles 1 to 8 after the trip. The limit flag is ignored at the cycle starts of those cycles.
- R3: If the limit flag is high at the cycle start of any of cycles 9 to 16 after the trip, `oc_latched` and `pg_low_req` go high from the clock after that strobe, and `hs_inhibit` stays high.
- R4: If the flag stays low at the cycle starts of cycles 9 to 16, `hs_inhibit` is low during those cycles. The strobe that starts cycle 17 is evaluated as a fresh sample, so a high flag there starts a new skip window.
- R5: Once latched, all three outputs stay high while `enable` is high, whatever the flag and strobe do.
- R6: While `enable` is low, all outputs are low on the next clock and strobes are ignored. When `enable` returns high, operation restarts from normal running.
- R7: Flag activity between cycle-start strobes has no effect on any output.
- R8: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (supply cycle) |
| enable | input | 1 | Channel enable; low clears the latch |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| ilim_flag | input | 1 | Current limit reached |
| hs_inhibit | output | 1 | Block the high-side drive |
| oc_latched | output | 1 | Over-current shutdown latched |
| pg_low_req | output | 1 | Request to pull power-good low |

## Verification
Every output is a register updated on the clock edge that samples a strobe. Each decision is therefore due one clock after its strobe and then holds, unchanged, until the next strobe. The bench drives the strobe half a period before the edge and reads the outputs on the following falling edge. It reads them again at the last falling edge before the next strobe, so a change in the middle of a cycle would be caught. The sweep places the second limit event at every cycle index from 1 to 17 after a trip. The expected inhibit and latch states are computed from the cycle index alone.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SKIP  = 2'd1,
        ST_PROBE = 2'd2,
        ST_LATCH = 2'd3
    } ocs_state_e;
endpackage

// File: rtl/ocs_strobe_qual.sv
module ocs_strobe_qual (
    input  logic enable,
    input  logic cyc_start,
    input  logic ilim_flag,
    output logic sample,
    output logic hit
);
    always_comb begin
        sample = enable & cyc_start;
        hit    = enable & cyc_start & ilim_flag;
    end
endmodule

// File: rtl/ocs_cycle_cnt.sv
module ocs_cycle_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] cnt_q
);
    logic [W-1:0] cnt_d;

    always_comb begin
        if (clr)
            cnt_d = step ? W'(1) : '0;
        else if (step)
            cnt_d = cnt_q + W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ocs_skip_seq.sv
module ocs_skip_seq #(
    parameter int SKIP_N  = 8,
    parameter int PROBE_N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cyc_start,
    input  logic ilim_flag,
    output logic hs_inhibit,
    output logic oc_latched,
    output logic pg_low_req
);
    import ocs_pkg::*;

    localparam int WIN_MAX = (SKIP_N > PROBE_N) ? SKIP_N : PROBE_N;
    localparam int CW      = $clog2(WIN_MAX + 1);

    typedef struct packed {
        ocs_state_e st;
        logic       inh;
        logic       lat;
    } ocs_regs_t;

    ocs_regs_t r_d, r_q;
    logic      sample, hit;
    logic      cnt_clr, cnt_step;
    logic [CW-1:0] cnt_q;

    ocs_strobe_qual u_qual (
        .enable    (enable),
        .cyc_start (cyc_start),
        .ilim_flag (ilim_flag),
        .sample    (sample),
        .hit       (hit)
    );

    ocs_cycle_cnt #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (cnt_step),
        .cnt_q (cnt_q)
    );

    always_comb begin
        r_d      = r_q;
        cnt_clr  = 1'b0;
        cnt_step = 1'b0;
        if (!enable) begin
            r_d.st  = ST_RUN;
            cnt_clr = 1'b1;
        end else begin
            case (r_q.st)
                ST_RUN: begin
                    if (hit) begin
                        r_d.st  = ST_SKIP;
                        cnt_clr = 1'b1;
                    end
                end
                ST_SKIP: begin
                    if (sample) begin
                        if (cnt_q == CW'(SKIP_N)) begin
                            if (ilim_flag) begin
                                r_d.st = ST_LATCH;
                            end else begin
                                r_d.st   = ST_PROBE;
                                cnt_clr  = 1'b1;
                                cnt_step = 1'b1;
                            end
                        end else begin
                            cnt_step = 1'b1;
                        end
                    end
                end
                ST_PROBE: begin
                    if (sample) begin
                        if (ilim_flag) begin
                            r_d.st = ST_LATCH;
                        end else if (cnt_q == CW'(PROBE_N - 1)) begin
                            r_d.st  = ST_RUN;
                            cnt_clr = 1'b1;
                        end else begin
                            cnt_step = 1'b1;
                        end
                    end
                end
                default: r_d.st = ST_LATCH;
            endcase
        end
        r_d.inh = (r_d.st == ST_SKIP) || (r_d.st == ST_LATCH);
        r_d.lat = (r_d.st == ST_LATCH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_RUN, inh: 1'b0, lat: 1'b0};
        else        r_q <= r_d;
    end

    assign hs_inhibit = r_q.inh;
    assign oc_latched = r_q.lat;
    assign pg_low_req = r_q.lat;

    AST_TRIP_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cyc_start && ilim_flag && r_q.st == ST_RUN) |=> hs_inhibit); // R1
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WIN_MAX)); // R2
    AST_LATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_latched) |-> $past(cyc_start && ilim_flag && enable)); // R3
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_latched && enable) |=> (oc_latched && hs_inhibit)); // R5
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!oc_latched && !hs_inhibit)); // R6
    AST_MIDCYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !cyc_start) |=> $stable({hs_inhibit, oc_latched})); // R7
endmodule

// File: tb/tb_ocs_skip_seq.sv
module tb_ocs_skip_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic cyc_start = 1'b0;
    logic ilim_flag = 1'b0;
    logic hs_inhibit, oc_latched, pg_low_req;
    int   n_checks = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    ocs_skip_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cyc_start  (cyc_start),
        .ilim_flag  (ilim_flag),
        .hs_inhibit (hs_inhibit),
        .oc_latched (oc_latched),
        .pg_low_req (pg_low_req)
    );

    task automatic check(string req, logic inh_exp, logic lat_exp);
        n_checks++;
        if (hs_inhibit !== inh_exp || oc_latched !== lat_exp || pg_low_req !== lat_exp) begin
            n_fail++;
            $display("FAIL %s: inh/lat/pg = %b/%b/%b expected %b/%b/%b",
                     req, hs_inhibit, oc_latched, pg_low_req, inh_exp, lat_exp, lat_exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // One switching cycle of 4 clocks: strobe with flag, then mid-cycle glitch level.
    task automatic run_cycle(logic flag, logic glitch, string req, logic inh_exp, logic lat_exp);
        @(negedge clk);
        cyc_start = 1'b1;
        ilim_flag = flag;
        @(negedge clk);
        cyc_start = 1'b0;
        ilim_flag = glitch;
        check(req, inh_exp, lat_exp);
        @(negedge clk);
        @(negedge clk);
        check({req, " R7 mid-cycle"}, inh_exp, lat_exp);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        check("R8 after reset", 1'b0, 1'b0);

        for (int k = 0; k <= 17; k++) begin
            run_cycle(1'b0, 1'b1, "R4 normal running", 1'b0, 1'b0);
            for (int c = 0; c <= 20; c++) begin
                logic fl, lat, inh;
                string rq;
                fl  = (c == 0) || (c == k);
                lat = (k >= 9) && (k <= 16) && (c >= k);
                inh = lat || (c <= 8) || (k == 17 && c >= 17);
                if (c == 0)       rq = "R1 trip";
                else if (c <= 8)  rq = "R2 skip window";
                else if (lat)     rq = "R3 latch";
                else              rq = "R4 probation/resume";
                run_cycle(fl, c[0], rq, inh, lat);
            end
            if ((k >= 9) && (k <= 16)) begin
                run_cycle(1'b0, 1'b0, "R5 latch holds", 1'b1, 1'b1);
                run_cycle(1'b1, 1'b1, "R5 latch holds flag", 1'b1, 1'b1);
            end
            @(negedge clk);
            enable = 1'b0;
            @(negedge clk);
            check("R6 disable clears", 1'b0, 1'b0);
            cyc_start = 1'b1;
            ilim_flag = 1'b1;
            @(negedge clk);
            cyc_start = 1'b0;
            ilim_flag = 1'b0;
            check("R6 strobe ignored when disabled", 1'b0, 1'b0);
            enable = 1'b1;
            @(negedge clk);
        end

        // Supply cycle releases a latch
        run_cycle(1'b1, 1'b0, "R1 trip", 1'b1, 1'b0);
        for (int c = 1; c <= 9; c++)
            run_cycle(c == 9, 1'b0, c == 9 ? "R3 latch" : "R2 skip window", 1'b1, c == 9);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset releases latch", 1'b0, 1'b0);
        rst_n = 1'b1;
        run_cycle(1'b0, 1'b1, "R4 normal after reset", 1'b0, 1'b0);
        summary();
    end
endmodule